// File: doc/BRIEF.md
# Buck PWM Cycle Timing Controller

This block is the digital timing core of a fixed-frequency step-down converter. It creates the switching cycle from a system clock. The cycle comes either from one of two internal rates, picked by the static level of a select/sync pin, or from falling edges on that same pin when an external clock drives it. At every cycle start it requests the high-side switch on. A PWM comparator trip or a current-limit trip of either polarity turns the switch off again. Every off interval lasts at least a minimum number of ticks.

If the output is still below regulation when a cycle ends and no trip has cut the on-time, the controller leaves out the off-time and carries the on-time into the next cycle. It does this for up to a parameter count of cycles in a row (three by default), so the effective switching rate drops by up to four. This raises the maximum duty factor in dropout. Sync edges that come sooner than the fastest acceptable period are discarded. If no edge arrives within the slowest acceptable period, the controller returns to the level-selected internal rate. All periods and limits are tick-count parameters.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: With the select pin held steady and no sync edge, cycle starts follow each other every PERIOD_LO_TICKS when the pin is low and every PERIOD_HI_TICKS when it is high. This holds while a comparator trip ends each on-time.
- R2: A falling edge on the select pin passes through a two-stage synchronizer and is then accepted. From the off state with the off-time satisfied, the switch turns on at the fourth clock edge after the pin falls. Accepted edges then set the cycle spacing.
- R3: A falling edge that comes less than SYNC_MIN_TICKS after the last accepted edge is ignored. It causes no switch-on and does not move the cycle timing.
- R4: When edge timing is in use and no edge is accepted within SYNC_MAX_TICKS of the last one, a cycle starts at that point and timing returns to the level-selected rate.
- R5: While the switch is on, a PWM trip, a positive current-limit trip or a negative current-limit trip turns the switch off at the next clock.
- R6: Any trip that is active when a switch-on is due wins over that request. The switch stays off for that cycle.
- R7: If the switch is still on at a cycle start, the out-of-regulation flag is high and no trip is active, the off-time is skipped. After MAX_SKIP skips in a row, the next cycle start forces the switch off. Sustained dropout therefore repeats every (MAX_SKIP+1) periods.
- R8: If the switch is still on at a cycle start and the out-of-regulation flag is low, the switch turns off. It turns on again once the minimum off-time has passed, and the cycle period is unchanged.
- R9: Every off interval of the high-side drive lasts at least MIN_OFF_TICKS clocks. A switch-on request that arrives earlier is held until that point.
- R10: The consecutive-skip count clears on every switch-off, including one caused by current limit. The first on-time after such a cut may again last MAX_SKIP+1 full periods.
- R11: During reset the drive is low and timing is level-selected. After reset is released with the pin low, the first switch-on follows PERIOD_LO_TICKS+1 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sync | input | 1 | Rate select level / external sync clock (falling edge active) |
| vout_low | input | 1 | Output voltage below regulation |
| pwm_trip | input | 1 | PWM comparator trip, ends the on-time |
| ilim_src | input | 1 | Current-limit trip, positive inductor current |
| ilim_snk | input | 1 | Current-limit trip, negative inductor current |
| hs_on | output | 1 | High-side switch drive |

## Verification
A wrong skip count shows up as an on-time of the wrong length in dropout, so the first long pulse after any switch-off exposes it, within MAX_SKIP+1 periods. A stuck edge-timing state shows up as cycle spacing that ignores the sync pin or never returns to the level rate, one SYNC_MAX_TICKS window after edges stop. A wrong off-time counter shows up as a low interval of the wrong width on the first forced or tripped switch-off. A lost pending request shows up as a missing pulse in that same period.

// File: rtl/pwm_cyc_pkg.sv
package pwm_cyc_pkg;

   // Source of cycle timing
   typedef enum logic {
      SRC_LEVEL = 1'b0,   // internal rate picked by pin level
      SRC_EDGE  = 1'b1    // locked to accepted falling edges
   } cyc_src_e;

   // Per-tick decision of the high-side latch
   typedef enum logic [2:0] {
      ACT_HOLD  = 3'd0,   // nothing changes
      ACT_SET   = 3'd1,   // switch on, request consumed
      ACT_CUT   = 3'd2,   // trip ends the on-time
      ACT_FORCE = 3'd3,   // cycle end without skip: off, re-request
      ACT_SKIP  = 3'd4,   // off-time skipped, on-time continues
      ACT_WAIT  = 3'd5,   // request held for minimum off-time
      ACT_DROP  = 3'd6    // request discarded by an active trip
   } latch_act_e;

endpackage

// File: rtl/pwm_sync_fall.sv
module pwm_sync_fall #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic lvl,
   output logic fall
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign lvl  = chain_q[STAGES-1];
   assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_cyc_pkg::*;
#(
   parameter int PERIOD_LO_TICKS = 500,
   parameter int PERIOD_HI_TICKS = 333,
   parameter int SYNC_MIN_TICKS  = 294,
   parameter int SYNC_MAX_TICKS  = 417
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic fall,
   output logic cyc_start
);

   localparam int TOP = (PERIOD_LO_TICKS > SYNC_MAX_TICKS) ? PERIOD_LO_TICKS : SYNC_MAX_TICKS;
   localparam int CW  = $clog2(TOP + 1);
   localparam int AW  = $clog2(SYNC_MAX_TICKS + 1);

   logic [CW-1:0] cnt_q;
   logic [AW-1:0] age_q;
   cyc_src_e      src_q;

   logic [CW-1:0] last_tick;
   logic          accept, expire, wrap, start;

   assign last_tick = lvl ? CW'(PERIOD_HI_TICKS - 1) : CW'(PERIOD_LO_TICKS - 1);

   // Edge accepted when free-running, or when spaced far enough from the last one
   assign accept = fall && ((src_q == SRC_LEVEL) || (age_q >= AW'(SYNC_MIN_TICKS - 1)));
   // Edge source silent for the slowest period: start here and fall back
   assign expire = (src_q == SRC_EDGE) && !accept && (age_q >= AW'(SYNC_MAX_TICKS - 1));
   // Internal rate
   assign wrap   = (src_q == SRC_LEVEL) && !accept && (cnt_q >= last_tick);
   assign start  = accept | expire | wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         age_q     <= AW'(SYNC_MAX_TICKS);
         src_q     <= SRC_LEVEL;
         cyc_start <= 1'b0;
      end else begin
         cyc_start <= start;
         cnt_q     <= start ? '0 : cnt_q + CW'(1);
         if (accept)
            age_q <= '0;
         else if (age_q < AW'(SYNC_MAX_TICKS))
            age_q <= age_q + AW'(1);
         if (accept)
            src_q <= SRC_EDGE;
         else if (expire)
            src_q <= SRC_LEVEL;
      end
   end

endmodule

// File: rtl/pwm_hs_latch.sv
module pwm_hs_latch
   import pwm_cyc_pkg::*;
#(
   parameter int MIN_OFF_TICKS = 30,
   parameter int MAX_SKIP      = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic vout_low,
   input  logic pwm_trip,
   input  logic ilim_src,
   input  logic ilim_snk,
   output logic hs_on
);

   localparam int OW = $clog2(MIN_OFF_TICKS + 1);

   logic          hs_q, pend_q;
   logic [OW-1:0] off_q;
   logic          trip, off_ok, skip_ok, want;
   latch_act_e    act;

   assign trip   = pwm_trip | ilim_src | ilim_snk;
   assign off_ok = (off_q >= OW'(MIN_OFF_TICKS));
   assign want   = cyc_start | pend_q;

   always_comb begin
      act = ACT_HOLD;
      if (hs_q) begin
         if (trip)
            act = ACT_CUT;
         else if (cyc_start)
            act = (vout_low && skip_ok) ? ACT_SKIP : ACT_FORCE;
      end else if (want) begin
         if (trip)
            act = ACT_DROP;
         else if (off_ok)
            act = ACT_SET;
         else
            act = ACT_WAIT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q   <= 1'b0;
         pend_q <= 1'b0;
         off_q  <= OW'(MIN_OFF_TICKS);
      end else begin
         case (act)
            ACT_SET: begin
               hs_q   <= 1'b1;
               pend_q <= 1'b0;
            end
            ACT_CUT: begin
               hs_q  <= 1'b0;
               off_q <= OW'(1);
            end
            ACT_FORCE: begin
               hs_q   <= 1'b0;
               pend_q <= 1'b1;
               off_q  <= OW'(1);
            end
            ACT_WAIT: pend_q <= 1'b1;
            ACT_DROP: pend_q <= 1'b0;
            default: ;
         endcase
         if (!hs_q && !off_ok && act != ACT_SET)
            off_q <= off_q + OW'(1);
      end
   end

   generate
      if (MAX_SKIP > 0) begin : g_skip
         localparam int SW = $clog2(MAX_SKIP + 1);
         logic [SW-1:0] skip_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               skip_q <= '0;
            else if (act == ACT_CUT || act == ACT_FORCE)
               skip_q <= '0;
            else if (act == ACT_SKIP)
               skip_q <= skip_q + SW'(1);
         end
         assign skip_ok = (skip_q < SW'(MAX_SKIP));
      end else begin : g_noskip
         assign skip_ok = 1'b0;
      end
   endgenerate

   assign hs_on = hs_q;

endmodule

// File: rtl/pwm_cycle_ctrl.sv
module pwm_cycle_ctrl #(
   parameter int PERIOD_LO_TICKS = 500,
   parameter int PERIOD_HI_TICKS = 333,
   parameter int SYNC_MIN_TICKS  = 294,
   parameter int SYNC_MAX_TICKS  = 417,
   parameter int MIN_OFF_TICKS   = 30,
   parameter int MAX_SKIP        = 3,
   parameter int SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_sync,
   input  logic vout_low,
   input  logic pwm_trip,
   input  logic ilim_src,
   input  logic ilim_snk,
   output logic hs_on
);

   generate
      if (PERIOD_HI_TICKS >= PERIOD_LO_TICKS) begin : g_chk_rate
         $error("high rate period must be shorter than low rate period");
      end
      if (SYNC_MIN_TICKS > SYNC_MAX_TICKS || SYNC_MIN_TICKS < 2) begin : g_chk_sync
         $error("sync window must satisfy 2 <= min <= max");
      end
      if (MIN_OFF_TICKS < 1 || MIN_OFF_TICKS >= PERIOD_HI_TICKS) begin : g_chk_off
         $error("minimum off-time must be at least 1 and below the short period");
      end
      if (MAX_SKIP < 0 || SYNC_STAGES < 2) begin : g_chk_misc
         $error("skip limit must be non-negative and synchronizer at least 2 stages");
      end
   endgenerate

   logic sync_lvl, sync_fall, cyc_start;

   pwm_sync_fall #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (rate_sync),
      .lvl  (sync_lvl),
      .fall (sync_fall)
   );

   pwm_timebase #(
      .PERIOD_LO_TICKS(PERIOD_LO_TICKS),
      .PERIOD_HI_TICKS(PERIOD_HI_TICKS),
      .SYNC_MIN_TICKS (SYNC_MIN_TICKS),
      .SYNC_MAX_TICKS (SYNC_MAX_TICKS)
   ) u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (sync_lvl),
      .fall     (sync_fall),
      .cyc_start(cyc_start)
   );

   pwm_hs_latch #(
      .MIN_OFF_TICKS(MIN_OFF_TICKS),
      .MAX_SKIP     (MAX_SKIP)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_start(cyc_start),
      .vout_low (vout_low),
      .pwm_trip (pwm_trip),
      .ilim_src (ilim_src),
      .ilim_snk (ilim_snk),
      .hs_on    (hs_on)
   );

endmodule

// File: rtl/pwm_cycle_ctrl_chk.sv
module pwm_cycle_ctrl_chk #(
   parameter int MIN_OFF  = 30,
   parameter int MAX_SKIP = 3
) (
   input logic clk,
   input logic rst_n,
   input logic hs_on,
   input logic cyc_start,
   input logic vout_low,
   input logic pwm_trip,
   input logic ilim_src,
   input logic ilim_snk
);

   localparam int LW = $clog2(MIN_OFF + 1);
   localparam int HW = $clog2(MAX_SKIP + 2);

   logic [LW-1:0] low_cnt;
   logic [HW-1:0] held_starts;
   logic          any_trip;

   assign any_trip = pwm_trip | ilim_src | ilim_snk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt     <= LW'(MIN_OFF);
         held_starts <= '0;
      end else begin
         if (hs_on)
            low_cnt <= '0;
         else if (low_cnt < LW'(MIN_OFF))
            low_cnt <= low_cnt + LW'(1);
         if (!hs_on)
            held_starts <= '0;
         else if (cyc_start && held_starts < HW'(MAX_SKIP + 1))
            held_starts <= held_starts + HW'(1);
      end
   end

   // R5: a trip while on ends the on-time at the next clock
   a_r5_trip_cuts: assert property (@(posedge clk) disable iff (!rst_n)
      hs_on && any_trip |=> !hs_on);

   // R6: a trip blocks a switch-on
   a_r6_trip_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_on && any_trip |=> !hs_on);

   // R7: after the allowed number of skipped off-times the next cycle start turns off
   a_r7_skip_limit: assert property (@(posedge clk) disable iff (!rst_n)
      hs_on && cyc_start && held_starts == HW'(MAX_SKIP) |=> !hs_on);

   // R8: cycle end in regulation turns the switch off
   a_r8_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
      hs_on && cyc_start && !vout_low |=> !hs_on);

   // R9: no switch-on before the minimum off-time has run
   a_r9_min_off: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_on && (int'(low_cnt) < MIN_OFF - 1) |=> !hs_on);

endmodule

bind pwm_cycle_ctrl pwm_cycle_ctrl_chk #(
   .MIN_OFF (MIN_OFF_TICKS),
   .MAX_SKIP(MAX_SKIP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hs_on    (hs_on),
   .cyc_start(cyc_start),
   .vout_low (vout_low),
   .pwm_trip (pwm_trip),
   .ilim_src (ilim_src),
   .ilim_snk (ilim_snk)
);

// File: tb/pwm_cycle_ctrl_test.sv
`timescale 1ns/1ps
module pwm_cycle_ctrl_test;

   localparam int P_LO  = 40;
   localparam int P_HI  = 30;
   localparam int S_MIN = 24;
   localparam int S_MAX = 34;
   localparam int T_OFF = 4;
   localparam int N_SKP = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rate_sync = 1'b0;
   logic vout_low = 1'b0;
   logic pwm_trip = 1'b0;
   logic ilim_src = 1'b0;
   logic ilim_snk = 1'b0;
   logic hs_on;

   int ticks = 0;
   int checks = 0;
   int errors = 0;
   int duty = 0;
   logic force_trip = 1'b0;
   int on_cnt = 0;
   int fall_count = 0;
   int rise_t [8];

   always #4 clk = ~clk;

   pwm_cycle_ctrl #(
      .PERIOD_LO_TICKS(P_LO),
      .PERIOD_HI_TICKS(P_HI),
      .SYNC_MIN_TICKS (S_MIN),
      .SYNC_MAX_TICKS (S_MAX),
      .MIN_OFF_TICKS  (T_OFF),
      .MAX_SKIP       (N_SKP),
      .SYNC_STAGES    (2)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sync(rate_sync),
      .vout_low (vout_low),
      .pwm_trip (pwm_trip),
      .ilim_src (ilim_src),
      .ilim_snk (ilim_snk),
      .hs_on    (hs_on)
   );

   always @(posedge clk) ticks <= ticks + 1;

   // Comparator model: trips after 'duty' sampled on-ticks
   always @(negedge clk) begin
      if (!hs_on) on_cnt = 0;
      else        on_cnt = on_cnt + 1;
      pwm_trip = force_trip || (duty > 0 && hs_on && on_cnt >= duty);
   end

   // Table: pin level, out-of-regulation flag, comparator duty, period, low width (-1: none)
   localparam int ROWS = 6;
   localparam int T_LVL [ROWS] = '{0, 1, 0, 0, 1, 0};
   localparam int T_OLO [ROWS] = '{0, 0, 0, 1, 1, 1};
   localparam int T_DTY [ROWS] = '{10, 10, 0, 0, 0, 10};
   localparam int T_PER [ROWS] = '{P_LO, P_HI, P_LO, 4*P_LO, 4*P_HI, P_LO};
   localparam int T_LOW [ROWS] = '{-1, -1, T_OFF, T_OFF, T_OFF, -1};

   function automatic string row_tag(int i);
      case (i)
         2:       return "R8";
         3, 4:    return "R7";
         default: return "R1";
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic next_edge(input logic lvl, output int t);
      logic prev = hs_on;
      int guard = 0;
      t = -1;
      while (guard < 2000) begin
         @(negedge clk);
         guard++;
         if (hs_on == lvl && prev != lvl) begin
            t = ticks;
            break;
         end
         prev = hs_on;
      end
      if (t < 0) begin
         checks++;
         errors++;
         $display("FAIL edge wait: actual=none expected=hs_on=%0d", lvl);
      end
   endtask

   task automatic sync_driver();
      @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         rate_sync = 1'b0;
         fall_count++;
         if (i == 3) begin
            repeat (5) @(negedge clk);
            rate_sync = 1'b1;
            repeat (5) @(negedge clk);
            rate_sync = 1'b0;          // too-early edge, must be ignored
            repeat (4) @(negedge clk);
            rate_sync = 1'b1;
            repeat (14) @(negedge clk);
         end else begin
            repeat (14) @(negedge clk);
            rate_sync = 1'b1;
            repeat (14) @(negedge clk);
         end
      end
      rate_sync = 1'b0;
      fall_count++;
   endtask

   task automatic sync_collect();
      int t;
      wait (fall_count >= 2);
      for (int k = 0; k < 8; k++) begin
         next_edge(1'b1, t);
         rise_t[k] = t;
      end
   endtask

   initial begin
      int r0, r1, f0, highs;
      // R11: reset state
      repeat (5) @(negedge clk);
      check("R11 drive low in reset", int'(hs_on), 0);
      rst_n = 1'b1;
      repeat (P_LO) @(negedge clk);
      check("R11 no switch-on before first period", int'(hs_on), 0);
      @(negedge clk);
      check("R11 first switch-on", int'(hs_on), 1);

      // Table walk: R1, R7, R8, R9
      for (int i = 0; i < ROWS; i++) begin
         rate_sync = T_LVL[i][0];
         vout_low  = T_OLO[i][0];
         duty      = T_DTY[i];
         repeat (500) @(negedge clk);
         next_edge(1'b1, r0);
         next_edge(1'b0, f0);
         next_edge(1'b1, r1);
         check(row_tag(i), r1 - r0, T_PER[i]);
         if (T_LOW[i] >= 0)
            check("R9 minimum off width", r1 - f0, T_LOW[i]);
      end

      // R5 and R10: current limit cuts and clears the skip count
      rate_sync = 1'b0; vout_low = 1'b1; duty = 0;
      repeat (500) @(negedge clk);
      next_edge(1'b1, r0);
      repeat (20) @(negedge clk);
      ilim_src = 1'b1;
      @(negedge clk);
      check("R5 positive limit cut", int'(hs_on), 0);
      ilim_src = 1'b0;
      next_edge(1'b1, r0);
      next_edge(1'b0, f0);
      check("R10 full skip run after limit", f0 - r0, 4*P_LO);
      next_edge(1'b1, r0);
      repeat (10) @(negedge clk);
      ilim_snk = 1'b1;
      @(negedge clk);
      check("R5 negative limit cut", int'(hs_on), 0);
      ilim_snk = 1'b0;

      // R6: trip held across cycle starts blocks every switch-on
      vout_low = 1'b0;
      force_trip = 1'b1;
      repeat (2) @(negedge clk);
      highs = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (hs_on) highs++;
      end
      check("R6 on-ticks under held trip", highs, 0);
      force_trip = 1'b0;

      // R2: synchronizer latency from an idle off state
      rate_sync = 1'b1; duty = 10;
      repeat (200) @(negedge clk);
      next_edge(1'b0, f0);
      repeat (6) @(negedge clk);
      rate_sync = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 not yet on after three clocks", int'(hs_on), 0);
      @(negedge clk);
      check("R2 on at fourth clock", int'(hs_on), 1);
      rate_sync = 1'b1;
      repeat (150) @(negedge clk);

      // R2, R3, R4: edge-locked timing, early edge, fallback
      fork
         sync_driver();
         sync_collect();
      join
      check("R2 edge-locked spacing", rise_t[1] - rise_t[0], 28);
      check("R3 early edge ignored", rise_t[3] - rise_t[2], 28);
      check("R4 fallback start", rise_t[6] - rise_t[5], S_MAX);
      check("R4 level rate resumes", rise_t[7] - rise_t[6], P_LO);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule